// File: doc/BRIEF.md
# Peripheral Rate-Control Flow Gate

This block paces a data mover's transfers to and from slow peripherals. Sixteen client slots each keep a small credit counter. A rising edge on the client's request line adds one credit, and each block the mover is granted removes one. Each slot also holds a size code that sets how many bytes one block carries, and a bank-select bit that picks which of two request-line banks feeds that slot.

The mover hands the gate one command word at a time. The gate reads a client number out of that word. Client number zero means the command is not throttled: blocks are offered at once. A nonzero client number makes the gate offer a block only while that client has credit.

Command intake and block grant are both valid/ready pairs. `cmd_ready` is high only while no command is open. Once a command is taken, `blk_valid` never depends on `blk_ready`. A block is granted on each clock edge where both `blk_valid` and `blk_ready` are high. The mover may hold `blk_ready` low for as long as it likes, and credits keep building while it does. `cmd_done` is a plain pulse that closes the open command.

Top module: `rate_gate`

## Requirements
- R1: After reset, `cmd_ready` is 1, `blk_valid` is 0, and every slot has zero credit, size code 0 and bank A selected.
- R2: A command is taken on an edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 and `blk_valid` may rise, until a `cmd_done` pulse makes `cmd_ready` 1 again on the next edge. While no command is open, `blk_valid` is 0.
- R3: The client number is taken from `cmd_word[6:3]` when that field is nonzero. Otherwise it is taken from `cmd_word[10:7]`.
- R4: With client number 0, `blk_valid` is 1 for the whole open command, `blk_bytes` is 0, and grants consume no credit.
- R5: One rising edge (0 then 1 on consecutive cycles) of a slot's selected request line adds exactly one credit. A line held high adds no more.
- R6: A slot's credit saturates at 15. Further edges are lost.
- R7: With a nonzero client, `blk_valid` is 1 exactly when that slot's credit is at least 1. Each grant subtracts one credit.
- R8: A write with `cfg_wdata[17]` set clears the addressed slot's credit on the write edge. This is a one-cycle strobe and is not stored. Other slots are untouched.
- R9: `cfg_wdata[18]` selects the request bank for the slot: 0 is `req_a`, 1 is `req_b`. Edges on the unselected bank add no credit.
- R10: `cfg_wdata[2:0]` is the size code. While a throttled command is open, `blk_bytes` shows the slot's size: code 0→16, 1→32, 2→64, 3→128, 4→192, 5→256.
- R11: A configuration write whose size code is 6 or 7 is dropped as a whole. Size, bank select and credit stay as they were.
- R12: Slots count credit whether or not a command is open.
- R13: A request edge and a grant on the same slot in the same cycle leave its credit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Slot addressed by the write |
| cfg_wdata | input | 19 | Write data: [2:0] size code, [17] credit clear, [18] bank select |
| req_a | input | 16 | Request lines, bank A, one per slot |
| req_b | input | 16 | Request lines, bank B, one per slot |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Gate can take a command |
| cmd_word | input | 11 | Command word: [6:3] source client, [10:7] destination client |
| cmd_done | input | 1 | Closes the open command |
| blk_valid | output | 1 | A block may be moved |
| blk_ready | input | 1 | Mover takes the offered block |
| blk_bytes | output | 9 | Byte size of the offered block, 0 when unthrottled |

## Verification
The hardest states to reach are the ones where two updates hit one counter in the same cycle. One is an edge that arrives at the exact edge where a grant consumes the last credit. The other is an edge arriving while the counter is already full. The bench reaches the first by leaving a command open with one credit, then raising the request line in the same cycle it raises `blk_ready`. It reaches the second by sending twenty edges while no command is open and then counting the grants that drain the slot. A count other than fifteen shows either lost saturation or a wrap-around.

// File: rtl/rate_gate_pkg.sv
package rate_gate_pkg;
  localparam int NUM_SLOTS = 16;
  localparam int CLIENT_W  = $clog2(NUM_SLOTS);
  localparam int CREDIT_W  = 4;
  localparam int CODE_W    = 3;
  localparam int BYTES_W   = 9;
  localparam int CLR_BIT   = 17;
  localparam int BANK_BIT  = 18;
  localparam int CFG_W     = BANK_BIT + 1;
  localparam int SRC_LSB   = 3;
  localparam int DST_LSB   = SRC_LSB + CLIENT_W;
  localparam int CMD_W     = DST_LSB + CLIENT_W;
  localparam int LAST_CODE = 5;

  typedef logic [CLIENT_W-1:0] client_t;
  typedef logic [CODE_W-1:0]   code_t;

  function automatic logic code_legal(input code_t c);
    return int'(c) <= LAST_CODE;
  endfunction

  function automatic client_t pick_client(input logic [CMD_W-1:0] w);
    client_t s;
    s = w[SRC_LSB +: CLIENT_W];
    return (s != '0) ? s : w[DST_LSB +: CLIENT_W];
  endfunction
endpackage

// File: rtl/rg_size_decode.sv
module rg_size_decode
  import rate_gate_pkg::*;
(
  input  logic               en,
  input  code_t              code,
  output logic [BYTES_W-1:0] bytes
);
  logic [BYTES_W-1:0] base;

  // Codes 0..3 double from 16 bytes; 4 and 5 break the pattern.
  always_comb begin
    unique case (code)
      3'd4:    base = BYTES_W'(192);
      3'd5:    base = BYTES_W'(256);
      default: base = BYTES_W'(16) << code[1:0];
    endcase
    bytes = en ? base : '0;
  end
endmodule

// File: rtl/rg_slot.sv
module rg_slot
  import rate_gate_pkg::*;
#(
  parameter int CW = CREDIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  code_t         wr_code,
  input  logic          wr_bank,
  input  logic          wr_clear,
  input  logic          req_a,
  input  logic          req_b,
  input  logic          take,
  output logic [CW-1:0] credit,
  output code_t         code
);
  localparam logic [CW-1:0] CMAX = '1;

  logic bank_q, prev_a, prev_b, rise, spend;

  always_comb begin
    rise  = bank_q ? (req_b & ~prev_b) : (req_a & ~prev_a);
    spend = take && (credit != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      prev_a <= req_a;
      prev_b <= req_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      code   <= '0;
    end else if (wr_en) begin
      bank_q <= wr_bank;
      code   <= wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit <= '0;
    end else if (wr_en && wr_clear) begin
      credit <= '0;
    end else begin
      unique case ({rise, spend})
        2'b10:   if (credit != CMAX) credit <= credit + 1'b1;
        2'b01:   credit <= credit - 1'b1;
        default: credit <= credit;
      endcase
    end
  end
endmodule

// File: rtl/rg_sequencer.sv
module rg_sequencer
  import rate_gate_pkg::*;
#(
  parameter int CW = CREDIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             cmd_done,
  input  logic [CW-1:0]    act_credit,
  output client_t          act_client,
  output logic             busy,
  output logic             blk_valid,
  input  logic             blk_ready,
  output logic             take
);
  typedef enum logic {ST_IDLE, ST_OPEN} st_t;
  st_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      act_client <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (cmd_valid) begin
          st         <= ST_OPEN;
          act_client <= pick_client(cmd_word);
        end
        ST_OPEN: if (cmd_done) st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st == ST_OPEN);
    cmd_ready = !busy;
    blk_valid = busy && ((act_client == '0) || (act_credit != '0));
    take      = blk_valid && blk_ready && (act_client != '0);
  end
endmodule

// File: rtl/rate_gate.sv
module rate_gate
  import rate_gate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [3:0]           cfg_idx,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic [NUM_SLOTS-1:0] req_a,
  input  logic [NUM_SLOTS-1:0] req_b,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [CMD_W-1:0]     cmd_word,
  input  logic                 cmd_done,
  output logic                 blk_valid,
  input  logic                 blk_ready,
  output logic [BYTES_W-1:0]   blk_bytes
);
  logic [CREDIT_W-1:0] credit [NUM_SLOTS];
  code_t               code   [NUM_SLOTS];
  logic [CREDIT_W-1:0] act_credit;
  code_t               act_code;
  client_t             act_client;
  logic                busy, take, wr_ok;
  code_t               wr_code;

  always_comb begin
    wr_code    = cfg_wdata[CODE_W-1:0];
    wr_ok      = cfg_we && code_legal(wr_code);
    act_credit = credit[act_client];
    act_code   = code[act_client];
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    rg_slot #(.CW(CREDIT_W)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ok && (cfg_idx == CLIENT_W'(i))),
      .wr_code  (wr_code),
      .wr_bank  (cfg_wdata[BANK_BIT]),
      .wr_clear (cfg_wdata[CLR_BIT]),
      .req_a    (req_a[i]),
      .req_b    (req_b[i]),
      .take     (take && (act_client == CLIENT_W'(i))),
      .credit   (credit[i]),
      .code     (code[i])
    );
  end

  rg_sequencer #(.CW(CREDIT_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_word   (cmd_word),
    .cmd_done   (cmd_done),
    .act_credit (act_credit),
    .act_client (act_client),
    .busy       (busy),
    .blk_valid  (blk_valid),
    .blk_ready  (blk_ready),
    .take       (take)
  );

  rg_size_decode size_i (
    .en    (busy && (act_client != '0)),
    .code  (act_code),
    .bytes (blk_bytes)
  );
endmodule

// File: rtl/rate_gate_chk.sv
module rate_gate_chk
  import rate_gate_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic                cmd_done,
  input logic                blk_valid,
  input logic [BYTES_W-1:0]  blk_bytes,
  input client_t             act_client,
  input logic [CREDIT_W-1:0] act_credit
);
  AST_IDLE_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !blk_valid); // R2

  AST_TAKE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R2

  AST_DONE_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && cmd_done) |=> cmd_ready); // R2

  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && act_client == '0) |-> (blk_valid && blk_bytes == '0)); // R4

  AST_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && act_client != '0) |-> (act_credit != '0)); // R7

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && act_client != '0) |->
      (blk_bytes inside {9'd16, 9'd32, 9'd64, 9'd128, 9'd192, 9'd256})); // R10
endmodule

bind rate_gate rate_gate_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_done   (cmd_done),
  .blk_valid  (blk_valid),
  .blk_bytes  (blk_bytes),
  .act_client (act_client),
  .act_credit (act_credit)
);

// File: tb/rate_gate_tb_top.sv
module rate_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [18:0] cfg_wdata = '0;
  logic [15:0] req_a = '0, req_b = '0;
  logic        cmd_valid = 1'b0, cmd_done = 1'b0, blk_ready = 1'b0;
  logic [10:0] cmd_word = '0;
  logic        cmd_ready, blk_valid;
  logic [8:0]  blk_bytes;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  rate_gate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_a(req_a), .req_b(req_b),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .cmd_done(cmd_done), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_bytes(blk_bytes)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int code, input bit bank, input bit clr);
    cfg_we = 1'b1; cfg_idx = 4'(idx);
    cfg_wdata = '0;
    cfg_wdata[2:0] = 3'(code); cfg_wdata[17] = clr; cfg_wdata[18] = bank;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic edge_on(input bit bank_b, input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      if (bank_b) req_b[idx] = 1'b1; else req_a[idx] = 1'b1;
      tick();
      if (bank_b) req_b[idx] = 1'b0; else req_a[idx] = 1'b0;
      tick();
    end
  endtask

  task automatic open_cmd(input int src, input int dst);
    cmd_valid = 1'b1;
    cmd_word = '0; cmd_word[6:3] = 4'(src); cmd_word[10:7] = 4'(dst);
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic close_cmd();
    cmd_done = 1'b1; tick(); cmd_done = 1'b0;
  endtask

  task automatic drain(output int n);
    n = 0; blk_ready = 1'b1;
    repeat (40) begin if (blk_valid) n++; tick(); end
    blk_ready = 1'b0;
  endtask

  function automatic int size_of(input int c);
    case (c)
      0: return 16; 1: return 32; 2: return 64;
      3: return 128; 4: return 192; default: return 256;
    endcase
  endfunction

  task automatic t_reset();
    check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    check(blk_valid == 1'b0, "R1 blk_valid", blk_valid, 0);
    for (int i = 0; i < 16; i++) cfg(i, 0, 1'b0, 1'b1);
  endtask

  task automatic t_free_run();
    int n;
    open_cmd(0, 0);
    check(cmd_ready == 1'b0, "R2 busy", cmd_ready, 0);
    check(blk_valid == 1'b1, "R4 valid", blk_valid, 1);
    check(blk_bytes == 9'd0, "R4 bytes", blk_bytes, 0);
    drain(n);
    check(n == 40, "R4 grants", n, 40);
    close_cmd();
    check(cmd_ready == 1'b1, "R2 reopen", cmd_ready, 1);
    check(blk_valid == 1'b0, "R2 idle", blk_valid, 0);
  endtask

  task automatic t_sizes();
    open_cmd(3, 0);
    for (int c = 0; c < 6; c++) begin
      cfg(3, c, 1'b0, 1'b0);
      edge_on(1'b0, 3, 1);
      check(int'(blk_bytes) == size_of(c), "R10 size", blk_bytes, size_of(c));
    end
    cfg(3, 6, 1'b0, 1'b1);
    check(blk_bytes == 9'd256, "R11 code kept", blk_bytes, 256);
    check(blk_valid == 1'b1, "R11 no clear", blk_valid, 1);
    close_cmd();
  endtask

  task automatic t_edges();
    int n;
    cfg(5, 2, 1'b0, 1'b0);
    edge_on(1'b0, 5, 2);
    req_a[5] = 1'b1; repeat (5) tick(); req_a[5] = 1'b0; tick();
    open_cmd(0, 5);
    check(blk_bytes == 9'd64, "R3 dst field", blk_bytes, 64);
    drain(n);
    check(n == 3, "R5 one per edge", n, 3);
    check(blk_valid == 1'b0, "R7 empty", blk_valid, 0);
    close_cmd();
  endtask

  task automatic t_saturate();
    int n;
    edge_on(1'b0, 7, 20);
    open_cmd(7, 0);
    drain(n);
    check(n == 15, "R6 R12 saturate", n, 15);
    close_cmd();
  endtask

  task automatic t_src_wins();
    int n;
    edge_on(1'b0, 7, 2);
    open_cmd(7, 5);
    check(blk_valid == 1'b1, "R3 src wins", blk_valid, 1);
    drain(n);
    check(n == 2, "R7 count", n, 2);
    close_cmd();
  endtask

  task automatic t_clear();
    edge_on(1'b0, 9, 4);
    edge_on(1'b0, 10, 2);
    cfg(9, 0, 1'b0, 1'b1);
    open_cmd(9, 0);
    check(blk_valid == 1'b0, "R8 cleared", blk_valid, 0);
    close_cmd();
    open_cmd(10, 0);
    check(blk_valid == 1'b1, "R8 neighbour kept", blk_valid, 1);
    close_cmd();
  endtask

  task automatic t_bank();
    cfg(11, 1, 1'b1, 1'b0);
    edge_on(1'b0, 11, 3);
    open_cmd(11, 0);
    check(blk_valid == 1'b0, "R9 bank A ignored", blk_valid, 0);
    edge_on(1'b1, 11, 1);
    check(blk_valid == 1'b1, "R9 bank B counts", blk_valid, 1);
    close_cmd();
  endtask

  task automatic t_same_cycle();
    edge_on(1'b0, 12, 1);
    open_cmd(12, 0);
    check(blk_valid == 1'b1, "R13 setup", blk_valid, 1);
    req_a[12] = 1'b1; blk_ready = 1'b1;
    tick();
    check(blk_valid == 1'b1, "R13 net zero", blk_valid, 1);
    req_a[12] = 1'b0;
    tick();
    blk_ready = 1'b0;
    check(blk_valid == 1'b0, "R13 then empty", blk_valid, 0);
    close_cmd();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_free_run();
    t_sizes();
    t_edges();
    t_saturate();
    t_src_wins();
    t_clear();
    t_bank();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule